// File: doc/BRIEF.md
# Dual-Slot Instruction Issue Sequencer

This block takes one 32-bit fetched instruction word at a time and turns it into an ordered series of one or two issue strobes toward an execute stage. A word holds either one 30-bit long instruction or two 15-bit short instructions: a left container in bits 29:15 and a right container in bits 14:0. The two top bits select one of four dispatch modes. Each mode fixes which container goes first and what stops the second from issuing. The execute stage answers each issue in the handshake cycle with three feedback bits: PC changed, exception raised and execute flag.

Whether a short instruction is condition-only is a decode result, so the fetch side supplies two flags, one per container, alongside the word. Five saturating counters record how many issues of each counted slot type have completed.

Top module: `dual_slot_issuer`

## Requirements
- R1: A word with bits 31:30 = 2'b11 issues exactly one slot of type LONG (slot code 0), with payload bits 29:0.
- R2: With bits 31:30 = 2'b10, the right container (bits 14:0) issues first as RIGHT (code 2), then the left container (bits 29:15) issues as LEFT (code 1). Short payloads are zero-extended to 30 bits.
- R3: With bits 31:30 = 2'b01, the left container issues first as LEFT, then the right container issues as RIGHT.
- R4: In both sequential modes (10 and 01), the second slot is skipped when pc_changed_i or exception_i is high in the first slot's handshake cycle.
- R5: With bits 31:30 = 2'b00 and a condition flag set, the flagged container issues first (left wins if both are flagged), using its own container type LEFT or RIGHT. The other container then issues, as its own container type, only if exec_flag_i was high in the first handshake.
- R6: With bits 31:30 = 2'b00 and no condition flag, the left container issues as LPAR (code 3) and then the right container as RPAR (code 4). The second slot is skipped only on exception_i; pc_changed_i has no effect.
- R7: word_ready_o is high only while no word is in flight, and issue_valid_o rises in the cycle after a word is accepted. While issue_valid_o is high and issue_ready_i is low, the slot type and payload hold.
- R8: done_o is high exactly in the handshake cycle that ends a word, whether that slot is the last one or the second slot is skipped.
- R9: Each completed issue increments the counter for its slot type by one, except the second slot of a condition-only pair, which is not counted.
- R10: Counters are CNT_W bits wide, stick at all ones, and clear on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_valid_i | input | 1 | Fetched word available |
| word_i | input | 32 | Fetched instruction word |
| cond_left_i | input | 1 | Left container holds a condition-only instruction |
| cond_right_i | input | 1 | Right container holds a condition-only instruction |
| word_ready_o | output | 1 | Sequencer can take a word |
| issue_valid_o | output | 1 | Issue strobe valid |
| issue_ready_i | input | 1 | Execute stage takes the issue |
| pc_changed_i | input | 1 | Feedback: issued slot changed the PC |
| exception_i | input | 1 | Feedback: issued slot raised an exception |
| exec_flag_i | input | 1 | Feedback: execute flag after the issued slot |
| issue_slot_o | output | 3 | Slot type code (0 LONG, 1 LEFT, 2 RIGHT, 3 LPAR, 4 RPAR) |
| issue_payload_o | output | 30 | Instruction payload |
| done_o | output | 1 | Final handshake of the current word |
| cnt_long_o | output | CNT_W | LONG issue count |
| cnt_left_o | output | CNT_W | LEFT issue count |
| cnt_right_o | output | CNT_W | RIGHT issue count |
| cnt_lpar_o | output | CNT_W | LPAR issue count |
| cnt_rpar_o | output | CNT_W | RPAR issue count |

## Verification
The hardest case to reach is a condition-only pair whose first issue returns a low execute flag. The same word must then show a skipped second slot, no count for that slot, and done_o in the first handshake, possibly after stall cycles. The bench drives the condition flags and the feedback per word, so each mode meets each gating input both asserted and deasserted. Some words also hold issue_ready_i low for several cycles before the handshake. Counter saturation is reached by building the bench with a 4-bit counter width and sending more long words than it can count.

// File: rtl/issue_pkg.sv
package issue_pkg;
  localparam int WORD_W  = 32;
  localparam int PAY_W   = 30;
  localparam int SHORT_W = 15;
  localparam int N_SLOT  = 5;

  typedef enum logic [2:0] {
    SLOT_LONG  = 3'd0,
    SLOT_LEFT  = 3'd1,
    SLOT_RIGHT = 3'd2,
    SLOT_LPAR  = 3'd3,
    SLOT_RPAR  = 3'd4
  } slot_e;

  typedef enum logic [1:0] {
    GATE_SINGLE,
    GATE_SEQ,
    GATE_COND,
    GATE_PAR
  } gate_e;

  typedef struct packed {
    slot_e             s0;
    logic [PAY_W-1:0]  p0;
    logic              c0;
    slot_e             s1;
    logic [PAY_W-1:0]  p1;
    logic              c1;
    gate_e             gate;
  } plan_t;
endpackage

// File: rtl/issue_decoder.sv
module issue_decoder
  import issue_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              cond_left_i,
  input  logic              cond_right_i,
  output plan_t             plan_o
);
  localparam int PAD_W = PAY_W - SHORT_W;

  logic [PAY_W-1:0] lft, rgt;
  assign lft = {{PAD_W{1'b0}}, word_i[PAY_W-1:SHORT_W]};
  assign rgt = {{PAD_W{1'b0}}, word_i[SHORT_W-1:0]};

  always_comb begin
    plan_o = '{s0: SLOT_LONG, p0: word_i[PAY_W-1:0], c0: 1'b1,
               s1: SLOT_LONG, p1: '0, c1: 1'b0, gate: GATE_SINGLE};
    unique case (word_i[WORD_W-1:WORD_W-2])
      2'b11: ;
      2'b10: plan_o = '{s0: SLOT_RIGHT, p0: rgt, c0: 1'b1,
                        s1: SLOT_LEFT,  p1: lft, c1: 1'b1, gate: GATE_SEQ};
      2'b01: plan_o = '{s0: SLOT_LEFT,  p0: lft, c0: 1'b1,
                        s1: SLOT_RIGHT, p1: rgt, c1: 1'b1, gate: GATE_SEQ};
      default: begin
        if (cond_left_i)
          plan_o = '{s0: SLOT_LEFT,  p0: lft, c0: 1'b1,
                     s1: SLOT_RIGHT, p1: rgt, c1: 1'b0, gate: GATE_COND};
        else if (cond_right_i)
          plan_o = '{s0: SLOT_RIGHT, p0: rgt, c0: 1'b1,
                     s1: SLOT_LEFT,  p1: lft, c1: 1'b0, gate: GATE_COND};
        else
          plan_o = '{s0: SLOT_LPAR,  p0: lft, c0: 1'b1,
                     s1: SLOT_RPAR,  p1: rgt, c1: 1'b1, gate: GATE_PAR};
      end
    endcase
  end
endmodule

// File: rtl/issue_sequencer.sv
module issue_sequencer
  import issue_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  plan_t             plan_i,
  output logic              word_ready_o,
  output logic              issue_valid_o,
  input  logic              issue_ready_i,
  input  logic              pc_changed_i,
  input  logic              exception_i,
  input  logic              exec_flag_i,
  output slot_e             slot_o,
  output logic [PAY_W-1:0]  payload_o,
  output logic [N_SLOT-1:0] cnt_sel_o,
  output logic              done_o
);
  logic  busy_q, phase_q;
  plan_t plan_q;
  logic  fire, skip, last, cur_cnt;

  assign word_ready_o  = !busy_q;
  assign issue_valid_o = busy_q;
  assign fire          = busy_q && issue_ready_i;
  assign slot_o        = phase_q ? plan_q.s1 : plan_q.s0;
  assign payload_o     = phase_q ? plan_q.p1 : plan_q.p0;
  assign cur_cnt       = phase_q ? plan_q.c1 : plan_q.c0;

  always_comb begin
    unique case (plan_q.gate)
      GATE_SEQ:  skip = pc_changed_i || exception_i;
      GATE_COND: skip = !exec_flag_i;
      GATE_PAR:  skip = exception_i;
      default:   skip = 1'b1;
    endcase
  end

  assign last   = phase_q || skip;
  assign done_o = fire && last;

  always_comb begin
    cnt_sel_o = '0;
    if (fire && cur_cnt) cnt_sel_o = {{(N_SLOT-1){1'b0}}, 1'b1} << slot_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      plan_q  <= '0;
    end else if (!busy_q) begin
      if (word_valid_i) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
        plan_q  <= plan_i;
      end
    end else if (fire) begin
      if (last) busy_q <= 1'b0;
      else      phase_q <= 1'b1;
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o && !issue_ready_i |=> issue_valid_o && $stable(slot_o) && $stable(payload_o));
  // R7
  ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(word_ready_o && issue_valid_o));
  // R8
  done_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> issue_valid_o && issue_ready_i);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> word_ready_o);
  // R1
  long_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && slot_o == SLOT_LONG |-> done_o);
  // R9
  one_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cnt_sel_o) && (cnt_sel_o == '0 || fire));
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end

  // R10
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o == MAX |=> cnt_o == MAX);
  // R9
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1));
  // R9
  idle_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o));
endmodule

// File: rtl/dual_slot_issuer.sv
module dual_slot_issuer
  import issue_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [31:0]       word_i,
  input  logic              cond_left_i,
  input  logic              cond_right_i,
  output logic              word_ready_o,
  output logic              issue_valid_o,
  input  logic              issue_ready_i,
  input  logic              pc_changed_i,
  input  logic              exception_i,
  input  logic              exec_flag_i,
  output logic [2:0]        issue_slot_o,
  output logic [29:0]       issue_payload_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  cnt_long_o,
  output logic [CNT_W-1:0]  cnt_left_o,
  output logic [CNT_W-1:0]  cnt_right_o,
  output logic [CNT_W-1:0]  cnt_lpar_o,
  output logic [CNT_W-1:0]  cnt_rpar_o
);
  plan_t             plan;
  slot_e             slot;
  logic [N_SLOT-1:0] cnt_sel;
  logic [CNT_W-1:0]  cnt_q [N_SLOT];

  issue_decoder u_dec (
    .word_i       (word_i),
    .cond_left_i  (cond_left_i),
    .cond_right_i (cond_right_i),
    .plan_o       (plan)
  );

  issue_sequencer u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .word_valid_i  (word_valid_i),
    .plan_i        (plan),
    .word_ready_o  (word_ready_o),
    .issue_valid_o (issue_valid_o),
    .issue_ready_i (issue_ready_i),
    .pc_changed_i  (pc_changed_i),
    .exception_i   (exception_i),
    .exec_flag_i   (exec_flag_i),
    .slot_o        (slot),
    .payload_o     (issue_payload_o),
    .cnt_sel_o     (cnt_sel),
    .done_o        (done_o)
  );

  assign issue_slot_o = slot;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (cnt_sel[g]),
      .cnt_o  (cnt_q[g])
    );
  end

  assign cnt_long_o  = cnt_q[SLOT_LONG];
  assign cnt_left_o  = cnt_q[SLOT_LEFT];
  assign cnt_right_o = cnt_q[SLOT_RIGHT];
  assign cnt_lpar_o  = cnt_q[SLOT_LPAR];
  assign cnt_rpar_o  = cnt_q[SLOT_RPAR];
endmodule

// File: tb/dual_slot_issuer_bench.sv
`timescale 1ns/1ps
module dual_slot_issuer_bench;
  localparam int CW  = 4;
  localparam int MAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic word_valid = 0, cond_l = 0, cond_r = 0;
  logic [31:0] word = '0;
  logic issue_ready = 0, pc_chg = 0, exc = 0, flag = 0;
  logic word_ready, issue_valid, done;
  logic [2:0] slot;
  logic [29:0] payload;
  logic [CW-1:0] c_long, c_left, c_right, c_lpar, c_rpar;

  int checks = 0, fails = 0;
  int m_cnt [5];

  always #10 clk = ~clk;

  dual_slot_issuer #(.CNT_W(CW)) u_dual_slot_issuer (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(word_valid), .word_i(word),
    .cond_left_i(cond_l), .cond_right_i(cond_r), .word_ready_o(word_ready),
    .issue_valid_o(issue_valid), .issue_ready_i(issue_ready),
    .pc_changed_i(pc_chg), .exception_i(exc), .exec_flag_i(flag),
    .issue_slot_o(slot), .issue_payload_o(payload), .done_o(done),
    .cnt_long_o(c_long), .cnt_left_o(c_left), .cnt_right_o(c_right),
    .cnt_lpar_o(c_lpar), .cnt_rpar_o(c_rpar)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_counts(input string req);
    check(c_long  == m_cnt[0], {req, " long count"},  c_long,  m_cnt[0]);
    check(c_left  == m_cnt[1], {req, " left count"},  c_left,  m_cnt[1]);
    check(c_right == m_cnt[2], {req, " right count"}, c_right, m_cnt[2]);
    check(c_lpar  == m_cnt[3], {req, " lpar count"},  c_lpar,  m_cnt[3]);
    check(c_rpar  == m_cnt[4], {req, " rpar count"},  c_rpar,  m_cnt[4]);
  endtask

  // Reference: codes 0 LONG, 1 LEFT, 2 RIGHT, 3 LPAR, 4 RPAR
  task automatic run_word(input logic [31:0] w, input logic cl, input logic cr,
                          input logic f_pc, input logic f_ex, input logic f_fl,
                          input int stall, input string req);
    int e_slot [2];
    logic [29:0] e_pay [2];
    bit e_cnt [2];
    int n;
    logic [29:0] l = {15'd0, w[29:15]};
    logic [29:0] r = {15'd0, w[14:0]};
    if (w[31:30] == 2'b11) begin
      e_slot[0] = 0; e_pay[0] = w[29:0]; e_cnt[0] = 1; n = 1;
    end else if (w[31:30] == 2'b10) begin
      e_slot = '{2, 1}; e_pay = '{r, l}; e_cnt = '{1, 1}; n = (f_pc || f_ex) ? 1 : 2;
    end else if (w[31:30] == 2'b01) begin
      e_slot = '{1, 2}; e_pay = '{l, r}; e_cnt = '{1, 1}; n = (f_pc || f_ex) ? 1 : 2;
    end else if (cl) begin
      e_slot = '{1, 2}; e_pay = '{l, r}; e_cnt = '{1, 0}; n = f_fl ? 2 : 1;
    end else if (cr) begin
      e_slot = '{2, 1}; e_pay = '{r, l}; e_cnt = '{1, 0}; n = f_fl ? 2 : 1;
    end else begin
      e_slot = '{3, 4}; e_pay = '{l, r}; e_cnt = '{1, 1}; n = f_ex ? 1 : 2;
    end

    @(negedge clk);
    word_valid = 1; word = w; cond_l = cl; cond_r = cr;
    #1 check(word_ready == 1, "R7 word_ready idle", word_ready, 1);
    @(posedge clk);
    @(negedge clk);
    word_valid = 0; word = ~w; cond_l = ~cl; cond_r = ~cr;
    #1 check(issue_valid == 1 && word_ready == 0, "R7 issue_valid after accept",
             {issue_valid, word_ready}, 2'b10);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < stall; k++) begin
        issue_ready = 0;
        #1 check(issue_valid && slot == e_slot[i] && payload == e_pay[i] && !done,
                 {"R7 hold ", req}, {slot, payload}, {e_slot[i][2:0], e_pay[i]});
        @(negedge clk);
      end
      issue_ready = 1;
      pc_chg = (i == 0) ? f_pc : 0;
      exc    = (i == 0) ? f_ex : 0;
      flag   = (i == 0) ? f_fl : 0;
      #1;
      check(slot == e_slot[i], {req, " slot"}, slot, e_slot[i]);
      check(payload == e_pay[i], {req, " payload"}, payload, e_pay[i]);
      check(done == (i == n - 1), {"R8 done ", req}, done, (i == n - 1));
      @(posedge clk);
      if (e_cnt[i] && m_cnt[e_slot[i]] < MAX) m_cnt[e_slot[i]]++;
      @(negedge clk);
      issue_ready = 0; pc_chg = 0; exc = 0; flag = 0;
    end
    #1;
    check(issue_valid == 0 && word_ready == 1, {"R8 idle after ", req},
          {issue_valid, word_ready}, 2'b01);
    check_counts({"R9 ", req});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    check(word_ready == 1 && issue_valid == 0 && done == 0, "R10 reset handshake",
          {word_ready, issue_valid, done}, 3'b100);
    check_counts("R10 reset");
    rst_n = 1;

    run_word(32'hC123_4567, 0, 0, 0, 0, 0, 0, "R1 long");
    run_word(32'hFFFF_FFFF, 1, 1, 1, 1, 0, 2, "R1 long ignores feedback");
    run_word(32'h9234_5ABC, 0, 0, 0, 0, 0, 0, "R2 right-then-left");
    run_word(32'hA5A5_1234, 0, 0, 1, 0, 0, 0, "R4 seq rl pc skip");
    run_word(32'h4ABC_7DEF, 0, 0, 0, 0, 0, 1, "R3 left-then-right");
    run_word(32'h7001_0002, 0, 0, 0, 1, 0, 0, "R4 seq lr exc skip");
    run_word(32'h5555_AAAA, 1, 1, 0, 0, 0, 0, "R3 cond flags ignored");
    run_word(32'h1234_5678, 1, 0, 0, 0, 1, 0, "R5 cond left taken");
    run_word(32'h1234_5678, 1, 0, 0, 0, 0, 3, "R5 cond left skipped");
    run_word(32'h0ACE_1357, 0, 1, 1, 1, 1, 0, "R5 cond right taken");
    run_word(32'h2468_0F0F, 0, 1, 0, 0, 0, 0, "R5 cond right skipped");
    run_word(32'h3FFF_0001, 1, 1, 0, 0, 1, 0, "R5 both cond left wins");
    run_word(32'h2BCD_4321, 0, 0, 0, 0, 0, 0, "R6 parallel");
    run_word(32'h1111_2222, 0, 0, 1, 0, 0, 2, "R6 parallel pc ignored");
    run_word(32'h3333_4444, 0, 0, 0, 1, 1, 0, "R6 parallel exc skip");
    for (int i = 0; i < MAX + 3; i++)
      run_word(32'hC000_0000 | i, 0, 0, 0, 0, 0, 0, "R10 long saturate");
    run_word(32'h8000_8001, 0, 0, 0, 0, 0, 0, "R9 after saturation");
    check(c_long == MAX, "R10 long stays max", c_long, MAX);

    @(negedge clk);
    rst_n = 0;
    for (int i = 0; i < 5; i++) m_cnt[i] = 0;
    #1 check_counts("R10 reset clears");
    @(negedge clk);
    rst_n = 1;
    run_word(32'h4000_0003, 0, 0, 0, 0, 0, 0, "R3 after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule